// File: doc/BRIEF.md
# Byte/Word Compare Flag Unit

This unit compares a destination operand against a source operand by forming destination minus source and keeping only the status that the subtraction produces. The difference itself is never driven out, and the operands are only read. A one-cycle compare strobe loads six arithmetic status bits into a flag register: borrow, low-byte parity, nibble borrow, zero, sign and signed overflow. The three control bits held in the same register (string direction, interrupt enable, single-step trap) keep their values across every compare.

A width select chooses between 8-bit and 16-bit operation. In byte mode only the low eight bits of each operand take part. A small condition evaluator reads the registered flags and presents signed and unsigned relations of the destination to the source, for use by a following conditional branch. The control bits can be written only through their own load strobe.

Top module: `cmp_flag_unit`

## Requirements
- R1: The arithmetic flags change only on a clock edge where `cmp_en` is 1. With `cmp_en` at 0 they hold their values.
- R2: `flg_cy` is 1 exactly when the destination is less than the source as unsigned numbers of the selected width, which is a borrow out of bit 7 (byte) or bit 15 (word).
- R3: `flg_aux` is 1 exactly when bits 3..0 of the destination are less than bits 3..0 of the source, which is a borrow into bit 4.
- R4: `flg_par` is 1 exactly when bits 7..0 of the difference hold an even number of ones, in both widths.
- R5: `flg_zr` is 1 exactly when the difference is zero at the selected width.
- R6: `flg_sg` equals the top bit of the difference at the selected width: bit 7 in byte mode, bit 15 in word mode.
- R7: `flg_ov` is 1 exactly when the true signed difference does not fit the selected width.
- R8: `flg_dir`, `flg_ien` and `flg_trp` are unchanged by compares. They load from `ctl_din` bits 0, 1 and 2 respectively only when `ctl_wr` is 1.
- R9: `cond_gt` = !zero & (sign == overflow); `cond_ge` = (sign == overflow); `cond_lt` = (sign != overflow); `cond_le` = zero | (sign != overflow). These give the signed relation of the destination to the source.
- R10: `cond_a` = !carry & !zero; `cond_ae` = !carry; `cond_b` = carry; `cond_be` = carry | zero; `cond_eq` = zero; `cond_ne` = !zero.
- R11: A synchronous `rst` at 1 clears every flag to 0 on the next clock edge.
- R12: In byte mode (`word_sel` = 0), bits 15..8 of both operands have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_en | input | 1 | One-cycle compare strobe |
| word_sel | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| dst_val | input | 16 | Destination operand |
| src_val | input | 16 | Source operand |
| ctl_wr | input | 1 | Load strobe for the control bits |
| ctl_din | input | 3 | Control bit values: bit 0 direction, bit 1 interrupt enable, bit 2 trap |
| flg_cy | output | 1 | Borrow flag |
| flg_par | output | 1 | Even parity of the low difference byte |
| flg_aux | output | 1 | Nibble borrow flag |
| flg_zr | output | 1 | Zero flag |
| flg_sg | output | 1 | Sign flag |
| flg_ov | output | 1 | Signed overflow flag |
| flg_dir | output | 1 | Direction control bit |
| flg_ien | output | 1 | Interrupt enable control bit |
| flg_trp | output | 1 | Trap control bit |
| cond_gt | output | 1 | Signed greater |
| cond_ge | output | 1 | Signed greater or equal |
| cond_lt | output | 1 | Signed less |
| cond_le | output | 1 | Signed less or equal |
| cond_a | output | 1 | Unsigned above |
| cond_ae | output | 1 | Unsigned above or equal |
| cond_b | output | 1 | Unsigned below |
| cond_be | output | 1 | Unsigned below or equal |
| cond_eq | output | 1 | Equal |
| cond_ne | output | 1 | Not equal |

## Verification
The assertions check several properties on every cycle. Arithmetic flags hold without a strobe, and control bits hold without their own load. The reset clears every flag. Equal operands give zero with no borrow, and an unsigned-smaller word destination gives a borrow. The condition outputs never contradict each other. The directed scenarios are the only way to show that each flag has the correct value across the two widths, at the signed overflow boundaries and at the nibble-borrow and parity cases. They also show that high operand bytes are ignored in byte mode, and that a control-bit load landing in the same cycle as a compare leaves each part of the register to its own source.

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit #(
  parameter int OP_W = 16,
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp_en,
  input  logic            word_sel,
  input  logic [OP_W-1:0] dst_val,
  input  logic [OP_W-1:0] src_val,
  input  logic            ctl_wr,
  input  logic [2:0]      ctl_din,
  output logic            flg_cy,
  output logic            flg_par,
  output logic            flg_aux,
  output logic            flg_zr,
  output logic            flg_sg,
  output logic            flg_ov,
  output logic            flg_dir,
  output logic            flg_ien,
  output logic            flg_trp,
  output logic            cond_gt,
  output logic            cond_ge,
  output logic            cond_lt,
  output logic            cond_le,
  output logic            cond_a,
  output logic            cond_ae,
  output logic            cond_b,
  output logic            cond_be,
  output logic            cond_eq,
  output logic            cond_ne
);

  localparam int NIB_W = 4;

  logic [OP_W:0]  wide_diff;
  logic [LO_W:0]  byte_diff;
  logic [NIB_W:0] nib_diff;

  assign wide_diff = {1'b0, dst_val} - {1'b0, src_val};
  assign byte_diff = {1'b0, dst_val[LO_W-1:0]} - {1'b0, src_val[LO_W-1:0]};
  assign nib_diff  = {1'b0, dst_val[NIB_W-1:0]} - {1'b0, src_val[NIB_W-1:0]};

  logic d_top, s_top, r_top;
  logic nx_cy, nx_par, nx_aux, nx_zr, nx_sg, nx_ov;

  assign d_top = word_sel ? dst_val[OP_W-1]   : dst_val[LO_W-1];
  assign s_top = word_sel ? src_val[OP_W-1]   : src_val[LO_W-1];
  assign r_top = word_sel ? wide_diff[OP_W-1] : byte_diff[LO_W-1];

  assign nx_cy  = word_sel ? wide_diff[OP_W] : byte_diff[LO_W];
  assign nx_aux = nib_diff[NIB_W];
  assign nx_par = ~^byte_diff[LO_W-1:0];
  assign nx_zr  = word_sel ? (wide_diff[OP_W-1:0] == '0) : (byte_diff[LO_W-1:0] == '0);
  assign nx_sg  = r_top;
  assign nx_ov  = (d_top ^ s_top) & (r_top ^ d_top);

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_cy  <= 1'b0;
      flg_par <= 1'b0;
      flg_aux <= 1'b0;
      flg_zr  <= 1'b0;
      flg_sg  <= 1'b0;
      flg_ov  <= 1'b0;
    end else if (cmp_en) begin
      flg_cy  <= nx_cy;
      flg_par <= nx_par;
      flg_aux <= nx_aux;
      flg_zr  <= nx_zr;
      flg_sg  <= nx_sg;
      flg_ov  <= nx_ov;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_dir <= 1'b0;
      flg_ien <= 1'b0;
      flg_trp <= 1'b0;
    end else if (ctl_wr) begin
      flg_dir <= ctl_din[0];
      flg_ien <= ctl_din[1];
      flg_trp <= ctl_din[2];
    end
  end

  logic sg_ne_ov;
  assign sg_ne_ov = flg_sg ^ flg_ov;

  assign cond_gt = ~flg_zr & ~sg_ne_ov;
  assign cond_ge = ~sg_ne_ov;
  assign cond_lt = sg_ne_ov;
  assign cond_le = flg_zr | sg_ne_ov;
  assign cond_a  = ~flg_cy & ~flg_zr;
  assign cond_ae = ~flg_cy;
  assign cond_b  = flg_cy;
  assign cond_be = flg_cy | flg_zr;
  assign cond_eq = flg_zr;
  assign cond_ne = ~flg_zr;

endmodule

// File: rtl/cmp_flag_unit_chk.sv
module cmp_flag_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmp_en,
  input logic        word_sel,
  input logic [15:0] dst_val,
  input logic [15:0] src_val,
  input logic        ctl_wr,
  input logic        flg_cy,
  input logic        flg_par,
  input logic        flg_aux,
  input logic        flg_zr,
  input logic        flg_sg,
  input logic        flg_ov,
  input logic        flg_dir,
  input logic        flg_ien,
  input logic        flg_trp,
  input logic        cond_gt,
  input logic        cond_le,
  input logic        cond_eq,
  input logic        cond_a,
  input logic        cond_ae,
  input logic        cond_b,
  input logic        cond_be
);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> !(flg_cy | flg_par | flg_aux | flg_zr | flg_sg | flg_ov | flg_dir | flg_ien | flg_trp));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> $stable({flg_cy, flg_par, flg_aux, flg_zr, flg_sg, flg_ov}));

  assert_ctl_kept_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable({flg_dir, flg_ien, flg_trp}));

  assert_equal_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && word_sel && dst_val == src_val) |=> (flg_zr && !flg_cy && !flg_ov));

  assert_byte_equal_R12: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !word_sel && dst_val[7:0] == src_val[7:0]) |=> (flg_zr && flg_par && !flg_sg));

  assert_word_borrow_R2: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && word_sel && dst_val < src_val) |=> (flg_cy && cond_b));

  assert_signed_consistent_R9: assert property (@(posedge clk) disable iff (rst)
    cond_gt |-> (!cond_le && !cond_eq));

  assert_unsigned_consistent_R10: assert property (@(posedge clk) disable iff (rst)
    cond_a |-> (!cond_be && cond_ae));

endmodule

bind cmp_flag_unit cmp_flag_unit_chk chk_i (.*);

// File: tb/cmp_flag_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmp_en;
  logic        word_sel;
  logic [15:0] dst_val;
  logic [15:0] src_val;
  logic        ctl_wr;
  logic [2:0]  ctl_din;
  logic flg_cy, flg_par, flg_aux, flg_zr, flg_sg, flg_ov, flg_dir, flg_ien, flg_trp;
  logic cond_gt, cond_ge, cond_lt, cond_le, cond_a, cond_ae, cond_b, cond_be, cond_eq, cond_ne;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_flag_unit dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_cmp(input logic [15:0] d, input logic [15:0] s, input logic w);
    dst_val = d; src_val = s; word_sel = w; cmp_en = 1'b1;
    tick();
    cmp_en = 1'b0;
  endtask

  task automatic expect_all(input logic [15:0] d, input logic [15:0] s, input logic w);
    int du, su, ds, ss, r, bits, lo, top;
    int e_cy, e_par, e_aux, e_zr, e_sg, e_ov, e_gt, e_lt, e_a, e_b;
    bits = w ? 16 : 8;
    du = w ? int'(d) : int'(d[7:0]);
    su = w ? int'(s) : int'(s[7:0]);
    ds = (du >= (1 << (bits-1))) ? du - (1 << bits) : du;
    ss = (su >= (1 << (bits-1))) ? su - (1 << bits) : su;
    r = (du - su) & ((1 << bits) - 1);
    lo = r & 255;
    e_par = 1;
    for (int i = 0; i < 8; i++) if ((lo >> i) & 1) e_par = 1 - e_par;
    top = (r >> (bits-1)) & 1;
    e_cy = (du < su) ? 1 : 0;
    e_aux = ((du & 15) < (su & 15)) ? 1 : 0;
    e_zr = (r == 0) ? 1 : 0;
    e_sg = top;
    e_ov = ((ds - ss) >= (1 << (bits-1)) || (ds - ss) < -(1 << (bits-1))) ? 1 : 0;
    e_gt = (ds > ss) ? 1 : 0;
    e_lt = (ds < ss) ? 1 : 0;
    e_a  = (du > su) ? 1 : 0;
    e_b  = (du < su) ? 1 : 0;
    chk("R2 carry", int'(flg_cy), e_cy);
    chk("R3 aux", int'(flg_aux), e_aux);
    chk("R4 parity", int'(flg_par), e_par);
    chk("R5 zero", int'(flg_zr), e_zr);
    chk("R6 sign", int'(flg_sg), e_sg);
    chk("R7 overflow", int'(flg_ov), e_ov);
    chk("R9 gt", int'(cond_gt), e_gt);
    chk("R9 ge", int'(cond_ge), 1 - e_lt);
    chk("R9 lt", int'(cond_lt), e_lt);
    chk("R9 le", int'(cond_le), 1 - e_gt);
    chk("R10 a", int'(cond_a), e_a);
    chk("R10 ae", int'(cond_ae), 1 - e_b);
    chk("R10 b", int'(cond_b), e_b);
    chk("R10 be", int'(cond_be), 1 - e_a);
    chk("R10 eq", int'(cond_eq), e_zr);
    chk("R10 ne", int'(cond_ne), 1 - e_zr);
  endtask

  task automatic cmp_and_check(input logic [15:0] d, input logic [15:0] s, input logic w);
    do_cmp(d, s, w);
    expect_all(d, s, w);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick();
    chk("R11 flags", int'({flg_cy, flg_par, flg_aux, flg_zr, flg_sg, flg_ov, flg_dir, flg_ien, flg_trp}), 0);
    rst = 1'b0; tick();
  endtask

  task automatic t_word_patterns();
    cmp_and_check(16'h1234, 16'h1234, 1'b1);
    cmp_and_check(16'h0001, 16'h0002, 1'b1);
    cmp_and_check(16'h8000, 16'h0001, 1'b1);
    cmp_and_check(16'h7FFF, 16'hFFFF, 1'b1);
    cmp_and_check(16'hFFFF, 16'h0000, 1'b1);
    cmp_and_check(16'h0010, 16'h0001, 1'b1);
    cmp_and_check(16'h4000, 16'hC000, 1'b1);
  endtask

  task automatic t_byte_patterns();
    cmp_and_check(16'h0080, 16'h0001, 1'b0);
    cmp_and_check(16'h007F, 16'h00FF, 1'b0);
    cmp_and_check(16'h0005, 16'h0007, 1'b0);
    cmp_and_check(16'h00FF, 16'h00FF, 1'b0);
    cmp_and_check(16'h0003, 16'h0000, 1'b0);
    cmp_and_check(16'h0020, 16'h0011, 1'b0);
  endtask

  task automatic t_byte_upper_ignored();
    cmp_and_check(16'hAB42, 16'h1142, 1'b0);
    chk("R12 zero with high bytes differing", int'(flg_zr), 1);
    cmp_and_check(16'h0010, 16'hFF20, 1'b0);
  endtask

  task automatic t_idle_hold();
    logic [5:0] snap;
    cmp_and_check(16'h0001, 16'h0003, 1'b1);
    snap = {flg_cy, flg_par, flg_aux, flg_zr, flg_sg, flg_ov};
    dst_val = 16'h5555; src_val = 16'h5555; word_sel = 1'b1;
    tick(); tick();
    chk("R1 hold without strobe", int'({flg_cy, flg_par, flg_aux, flg_zr, flg_sg, flg_ov}), int'(snap));
  endtask

  task automatic t_ctl_preserve();
    ctl_din = 3'b101; ctl_wr = 1'b1; tick(); ctl_wr = 1'b0;
    chk("R8 ctl load", int'({flg_trp, flg_ien, flg_dir}), 5);
    cmp_and_check(16'h0000, 16'hFFFF, 1'b1);
    chk("R8 ctl across compare", int'({flg_trp, flg_ien, flg_dir}), 5);
    ctl_din = 3'b010; ctl_wr = 1'b1;
    do_cmp(16'h0044, 16'h0044, 1'b0);
    ctl_wr = 1'b0;
    chk("R8 ctl load with compare", int'({flg_trp, flg_ien, flg_dir}), 2);
    chk("R5 zero with ctl load", int'(flg_zr), 1);
    ctl_din = 3'b111; tick();
    chk("R8 ctl din ignored without load", int'({flg_trp, flg_ien, flg_dir}), 2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmp_en = 1'b0; word_sel = 1'b1; dst_val = '0; src_val = '0;
    ctl_wr = 1'b0; ctl_din = '0;
    tick();
    t_reset();
    t_word_patterns();
    t_byte_patterns();
    t_byte_upper_ignored();
    t_idle_hold();
    t_ctl_preserve();
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule